// File: doc/BRIEF.md
# SPI Master Baud Rate Generator

This block holds the 8-bit rate control register of an SPI master and turns the bus clock into serial clock edge enables. The register has two 3-bit fields. One is a linear preselect value P, giving a factor of P+1 (1 to 8). The other is a power value S, giving a factor of 2^(S+1) (2 to 256). One serial clock period lasts D = (P+1)·2^(S+1) bus clocks, so D runs from 2 to 2048.

While the shift engine signals that a transfer is running, the divider counts bus clocks. Every D/2 bus clocks it emits a one-cycle tick. The ticks alternate between a leading-edge enable and a trailing-edge enable, starting with the leading edge. When no transfer is running, the counter stays at zero, so a new transfer always begins with a full half period.

If a write changes either field while a transfer is running, the block raises a one-cycle abort pulse so the engine can drop to idle. It also restarts the divider with the new divisor. A write that leaves both fields unchanged does not disturb anything.

Top module: `spi_baud_gen`

## Requirements
- R1: After reset, `rd_data` reads 0x00, so the divisor is 2, and `lead_tick`, `trail_tick` and `abort` are all low.
- R2: A write stores bits 6:4 as the preselect field P and bits 2:0 as the power field S. Bits 7 and 3 always read 0 (writing 0xFF reads back 0x77). `rd_data` changes only in the cycle after a write.
- R3: With half period H = (P+1)·2^S, the first `lead_tick` is high H cycles after `xfer_active` rises. Each later tick follows the previous one by H cycles, so one full period is 2H = D cycles. This holds for all 64 field combinations.
- R4: Ticks alternate in the order lead, trail, lead, and so on. `lead_tick` and `trail_tick` are never high in the same cycle, and each tick is one cycle wide.
- R5: A write that changes P or S while `xfer_active` is high raises `abort` in the next cycle, for exactly one cycle.
- R6: A write that leaves P and S unchanged while `xfer_active` is high produces no abort and leaves the tick timing undisturbed. This includes a write that differs only in bits 7 or 3.
- R7: A write that changes P or S while `xfer_active` is low produces no abort, but the new value is still stored.
- R8: While `xfer_active` is low, no ticks appear. After an abort with `xfer_active` still high, the next `lead_tick` comes H' cycles after `abort`, where H' is the half period of the new divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| xfer_active | input | 1 | High while the shift engine runs a transfer |
| lead_tick | output | 1 | Leading serial clock edge enable |
| trail_tick | output | 1 | Trailing serial clock edge enable |
| abort | output | 1 | One-cycle request to drop the transfer |

## Verification
Every output is a register, so each result follows its cause by a fixed number of bus clocks:
- Register contents and `abort` appear one cycle after the write edge.
- The first leading tick appears H cycles after the activity rise.
- Each later tick appears H cycles after the one before it.
- After an abort, the next leading tick appears H' cycles after the abort pulse.

The bench drives inputs and samples outputs on the falling clock edge. It counts falling edges from each stimulus and compares the count at which a tick or pulse appears against H or H' computed from the written fields. It also confirms that the pulse or tick is absent on the other edges it passes.

// File: rtl/spi_baud_gen.sv
module spi_baud_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       xfer_active,
  output logic       lead_tick,
  output logic       trail_tick,
  output logic       abort
);
  localparam int FW = 3;
  localparam int HW = FW + 1 + (1 << FW) - 1;

  logic [FW-1:0] pre, pw;
  logic [HW-1:0] cnt, half;
  logic          phase;

  wire field_change = wr_en && (wr_data[6:4] != pre || wr_data[2:0] != pw);
  wire restart      = !xfer_active || (field_change && xfer_active);

  assign half    = (HW'(pre) + HW'(1)) << pw;
  assign rd_data = {1'b0, pre, 1'b0, pw};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre   <= '0;
      pw    <= '0;
      abort <= 1'b0;
    end else begin
      if (wr_en) begin
        pre <= wr_data[6:4];
        pw  <= wr_data[2:0];
      end
      abort <= field_change && xfer_active;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt        <= '0;
      phase      <= 1'b0;
      lead_tick  <= 1'b0;
      trail_tick <= 1'b0;
    end else if (cnt == half - HW'(1)) begin
      cnt        <= '0;
      phase      <= ~phase;
      lead_tick  <= ~phase;
      trail_tick <= phase;
    end else begin
      cnt        <= cnt + HW'(1);
      lead_tick  <= 1'b0;
      trail_tick <= 1'b0;
    end
  end
endmodule

module spi_baud_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] rd_data,
  input logic       xfer_active,
  input logic       lead_tick,
  input logic       trail_tick,
  input logic       abort
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] == 1'b0 && rd_data[3] == 1'b0);
  p_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
  p_ticks_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_tick && trail_tick));
  p_lead_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lead_tick |=> !lead_tick);
  p_abort_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort) |-> $past(wr_en) && $past(xfer_active));
  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |=> !abort);
  p_idle_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |=> !lead_tick && !trail_tick);
  p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !lead_tick && !trail_tick);
endmodule

bind spi_baud_gen spi_baud_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
  .xfer_active(xfer_active), .lead_tick(lead_tick),
  .trail_tick(trail_tick), .abort(abort));

// File: tb/spi_baud_gen_test.sv
module spi_baud_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       xfer_active = 1'b0;
  logic [7:0] rd_data;
  logic       lead_tick, trail_tick, abort;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  spi_baud_gen uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .xfer_active(xfer_active), .lead_tick(lead_tick),
    .trail_tick(trail_tick), .abort(abort));

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int half_of(input logic [7:0] v);
    return (int'(v[6:4]) + 1) << v[2:0];
  endfunction

  task automatic write_reg(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick(input bit want_lead, output int n, output bit other);
    n = 0; other = 1'b0;
    do begin
      @(negedge clk); n++;
      if (want_lead ? trail_tick : lead_tick) other = 1'b1;
    end while (!(want_lead ? lead_tick : trail_tick) && n < 5000);
  endtask

  task automatic t_reset();
    check("R1 rd_data", rd_data, 0);
    check("R1 ticks", {lead_tick, trail_tick, abort}, 0);
  endtask

  task automatic t_fields();
    write_reg(8'hFF);
    check("R2 reserved read as zero", rd_data, 8'h77);
    write_reg(8'h25);
    check("R2 field store", rd_data, 8'h25);
    repeat (3) @(negedge clk);
    check("R8 idle no ticks", lead_tick | trail_tick, 0);
  endtask

  task automatic t_all_rates();
    int n; bit oth; int bad;
    bad = 0;
    for (int v = 0; v < 64; v++) begin
      logic [7:0] val;
      int h;
      val = {1'b0, v[5:3], 1'b0, v[2:0]};
      h = half_of(val);
      write_reg(val);
      xfer_active = 1'b1;
      wait_tick(1'b1, n, oth);
      if (n != h || oth) begin bad++; check("R3 first lead", n, h); end
      wait_tick(1'b0, n, oth);
      if (n != h || oth) begin bad++; check("R4 lead to trail", n, h); end
      wait_tick(1'b1, n, oth);
      if (n != h || oth) begin bad++; check("R3 trail to lead", n, h); end
      xfer_active = 1'b0;
      @(negedge clk);
    end
    check("R3 all 64 divisors", bad, 0);
  endtask

  task automatic t_abort();
    int n; bit oth;
    write_reg(8'h11);
    xfer_active = 1'b1;
    repeat (2) @(negedge clk);
    write_reg(8'h32);
    check("R5 abort raised", abort, 1);
    @(negedge clk);
    check("R5 abort one cycle", abort, 0);
    n = 1;
    while (!lead_tick && n < 5000) begin @(negedge clk); n++; end
    check("R8 restart after abort", n, half_of(8'h32));
    xfer_active = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_same_write();
    int n; bit ab;
    write_reg(8'h11);
    xfer_active = 1'b1;
    @(negedge clk); n = 1;
    ab = 1'b0;
    write_reg(8'h11); n++; ab |= abort;
    write_reg(8'h99); n++; ab |= abort;
    check("R6 no abort", ab, 0);
    check("R6 reserved ignored", rd_data, 8'h11);
    while (!lead_tick && n < 5000) begin @(negedge clk); n++; end
    check("R6 timing undisturbed", n, half_of(8'h11));
    xfer_active = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_idle_write();
    write_reg(8'h47);
    check("R7 no abort when idle", abort, 0);
    check("R7 value stored", rd_data, 8'h47);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_all_rates();
    t_abort();
    t_same_write();
    t_idle_write();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (190000) @(posedge clk); end
    join_any
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule